// File: doc/BRIEF.md
# Ternary Multiply-Accumulate Tile

This block is a row of parallel accumulate lanes for ternary-weight arithmetic. Each lane takes a two-bit weight code and a signed 8-bit activation. It adds the activation to its own 24-bit accumulator, subtracts it, or leaves the accumulator as it is. No multiplier is used. The choice is made by sign-select gating on the weight code.

When a lane's weight is zero or its activation is zero, the accumulator register is not enabled on that cycle. Every valid cycle adds the number of such lanes to a shared 32-bit counter. A full matrix of rows x cols elements therefore takes (rows*cols)/LANES issue cycles when nothing stalls.

A synchronous clear empties every accumulator and the counter. Results are read one lane at a time through an indexed port with one cycle of latency.

Top module: `ternary_mac_tile`

## Requirements
- R1: After reset every accumulator reads 0, `skip_count` is 0 and `rd_data` is 0.
- R2: On a valid cycle without clear, a lane with weight code 2'b01 (+1) and a nonzero activation adds the sign-extended activation to its accumulator.
- R3: On a valid cycle without clear, a lane with weight code 2'b11 (-1) and a nonzero activation subtracts the sign-extended activation. A negative activation therefore raises the sum.
- R4: A lane with weight code 2'b00 or 2'b10 keeps its accumulator unchanged.
- R5: A lane whose activation is 8'h00 keeps its accumulator unchanged, whatever its weight code.
- R6: While `in_valid` is low and `clr` is low, no accumulator and not `skip_count` changes, whatever the weights and activations.
- R7: Each valid cycle without clear, `skip_count` grows by the number of lanes whose weight code is 2'b00 or 2'b10 or whose activation is zero.
- R8: `clr` high at a clock edge sets all accumulators and `skip_count` to 0. This takes priority over an accumulate on the same cycle.
- R9: Accumulators wrap modulo 2^24 as two's-complement values.
- R10: `rd_data` at the edge after `rd_idx` is presented equals the value that lane's accumulator held before that edge. An index of LANES or above returns 0.
- R11: Each lane's accumulator depends only on its own weight and activation fields. Lane k uses `weights[2k+1:2k]` and `acts[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of accumulators and skip counter |
| in_valid | input | 1 | Weights and activations are valid this cycle |
| weights | input | 2*LANES | Per-lane weight code, lane k at bits 2k+1:2k |
| acts | input | 8*LANES | Per-lane signed activation, lane k at bits 8k+7:8k |
| rd_idx | input | clog2(LANES) | Lane to read |
| rd_data | output | 24 | Registered accumulator value of the selected lane |
| skip_count | output | 32 | Total of skipped lane operations |

## Verification
An accumulate or clear presented at an edge shows in `skip_count` directly after that edge. It shows in a lane's accumulator at the same time, but the accumulator can only be seen one edge later through the read port, so reading lane k takes two edges from the stimulus.

The bench drives inputs on the falling edge. It updates its reference model at the rising edge and samples on the next falling edge. To read an accumulator it holds `in_valid` low for the read cycle, so the value returned is exactly the model state.

// File: rtl/ternary_mac_tile.sv
module ternary_mac_tile #(
  parameter int LANES = 15,
  parameter int ACT_W = 8,
  parameter int ACC_W = 24,
  parameter int CNT_W = 32,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   in_valid,
  input  logic [2*LANES-1:0]     weights,
  input  logic [ACT_W*LANES-1:0] acts,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [ACC_W-1:0]       rd_data,
  output logic [CNT_W-1:0]       skip_count
);

  logic [ACC_W-1:0] acc_q [LANES];
  logic [ACC_W-1:0] delta [LANES];
  logic [LANES-1:0] live;
  logic [CNT_W-1:0] n_skip;
  logic             rd_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0]       w_c;
    logic [ACT_W-1:0] a_c;
    logic [ACC_W-1:0] a_ext;
    assign w_c      = weights[2*i +: 2];
    assign a_c      = acts[ACT_W*i +: ACT_W];
    assign a_ext    = {{(ACC_W-ACT_W){a_c[ACT_W-1]}}, a_c};
    assign live[i]  = w_c[0] && (a_c != '0);
    assign delta[i] = w_c[1] ? (~a_ext + 1'b1) : a_ext;
  end

  always_comb begin
    n_skip = '0;
    for (int k = 0; k < LANES; k++) n_skip += CNT_W'(!live[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < LANES; k++) acc_q[k] <= '0;
      skip_count <= '0;
    end else if (in_valid) begin
      for (int k = 0; k < LANES; k++)
        if (live[k]) acc_q[k] <= acc_q[k] + delta[k];
      skip_count <= skip_count + n_skip;
    end
  end

  assign rd_ok = {1'b0, rd_idx} < (IDX_W+1)'(LANES);

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_ok) rd_data <= acc_q[rd_idx];
    else            rd_data <= '0;
  end

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_valid) |=> $stable(skip_count));
  p_skip_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && in_valid) |=> (skip_count - $past(skip_count)) <= CNT_W'(LANES));
  p_clear_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> skip_count == '0);
  p_rd_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> rd_data == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_null_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !weights[2*g]) |=> $stable(acc_q[g]));
    p_zero_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && acts[ACT_W*g +: ACT_W] == '0) |=> $stable(acc_q[g]));
    p_idle_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !in_valid) |=> $stable(acc_q[g]));
    p_clear_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc_q[g] == '0);
    p_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == IDX_W'(g)) |=> rd_data == $past(acc_q[g]));
  end

endmodule

// File: tb/tb_ternary_mac_tile.sv
module tb_ternary_mac_tile;
  localparam int L = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic [2*L-1:0] weights = '0;
  logic [8*L-1:0] acts = '0;
  logic [3:0] rd_idx = '0;
  logic [23:0] rd_data;
  logic [31:0] skip_count;

  int total = 0;
  int bad = 0;

  logic [1:0]         w_v [L];
  logic signed [7:0]  a_v [L];
  logic signed [23:0] m_acc [L];
  logic [31:0]        m_skip;

  always #2 clk = ~clk;

  ternary_mac_tile dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .weights(weights), .acts(acts), .rd_idx(rd_idx),
    .rd_data(rd_data), .skip_count(skip_count)
  );

  function automatic logic lane_live(logic [1:0] w, logic signed [7:0] a);
    return w[0] && (a != 0);
  endfunction

  function automatic logic signed [23:0] lane_next(logic signed [23:0] acc,
      logic [1:0] w, logic signed [7:0] a);
    logic signed [23:0] e;
    e = a;
    if (!lane_live(w, a)) return acc;
    return w[1] ? acc - e : acc + e;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clear_vec();
    for (int k = 0; k < L; k++) begin w_v[k] = 2'b00; a_v[k] = 8'sd0; end
  endtask

  task automatic apply(logic v, logic c);
    for (int k = 0; k < L; k++) begin
      weights[2*k +: 2] = w_v[k];
      acts[8*k +: 8]    = a_v[k];
    end
    in_valid = v;
    clr = c;
    @(posedge clk);
    if (c) begin
      for (int k = 0; k < L; k++) m_acc[k] = '0;
      m_skip = '0;
    end else if (v) begin
      for (int k = 0; k < L; k++) begin
        if (!lane_live(w_v[k], a_v[k])) m_skip++;
        m_acc[k] = lane_next(m_acc[k], w_v[k], a_v[k]);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b0;
  endtask

  task automatic rd(int lane, string req);
    logic [23:0] e;
    rd_idx = 4'(lane);
    in_valid = 1'b0;
    clr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    e = (lane < L) ? m_acc[lane] : 24'd0;
    chk(req, {8'd0, rd_data}, {8'd0, e});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    for (int k = 0; k < L; k++) m_acc[k] = '0;
    m_skip = '0;
    clear_vec();
    repeat (3) @(negedge clk);
    chk("R1 rd_data", {8'd0, rd_data}, 32'd0);
    rst_n = 1'b1;
    chk("R1 skip_count", skip_count, 32'd0);
    rd(0, "R1 lane0");
    rd(14, "R1 lane14");

    clear_vec();
    w_v[0] = 2'b01; a_v[0] = 8'sd5;
    w_v[1] = 2'b11; a_v[1] = 8'sd7;
    w_v[2] = 2'b00; a_v[2] = 8'sd9;
    w_v[3] = 2'b10; a_v[3] = 8'sd9;
    w_v[4] = 2'b01; a_v[4] = 8'sd0;
    w_v[5] = 2'b11; a_v[5] = -8'sd128;
    w_v[6] = 2'b01; a_v[6] = -8'sd3;
    apply(1'b1, 1'b0);
    chk("R7 skip after directed", skip_count, 32'd11);
    chk("R2 lane0 model", {8'd0, m_acc[0]}, 32'd5);
    rd(0, "R2 add +5");
    rd(1, "R3 sub 7");
    rd(2, "R4 code 00");
    rd(3, "R4 code 10");
    rd(4, "R5 zero act");
    rd(5, "R3 sub -128");
    rd(6, "R2 add -3");
    rd(15, "R10 out of range");

    for (int k = 0; k < L; k++) begin w_v[k] = 2'b01; a_v[k] = 8'sd1; end
    apply(1'b0, 1'b0);
    chk("R6 idle skip", skip_count, 32'd11);
    rd(0, "R6 idle lane0");
    rd(7, "R6 idle lane7");

    apply(1'b1, 1'b1);
    chk("R8 clear wins count", skip_count, 32'd0);
    rd(0, "R8 clear wins lane0");
    rd(5, "R8 clear wins lane5");

    clear_vec();
    w_v[0] = 2'b11; a_v[0] = -8'sd128;
    for (int n = 0; n < 65537; n++) apply(1'b1, 1'b0);
    chk("R9 model wrap", {8'd0, m_acc[0]}, {8'd0, 24'(-8388480)});
    rd(0, "R9 wrap lane0");
    chk("R7 skip long run", skip_count, 32'd917518);
    apply(1'b0, 1'b1);

    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < L; k++) begin
        w_v[k] = 2'($urandom_range(0, 3));
        a_v[k] = ($urandom_range(0, 3) == 0) ? 8'sd0 : 8'($urandom);
      end
      apply(1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 199) == 0));
      chk("R7 random skip", skip_count, m_skip);
      if (n % 150 == 149)
        for (int k = 0; k < L; k++) rd(k, "R11 random lane");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule